// File: doc/BRIEF.md
# Snapshot Arbiter with Selectable Group or Linear Priority

This block shares one resource among a parameterised set of clients, four by default, split into two groups of two. Arbitration happens in two stages. First a lock register captures the whole request vector in a single cycle, at an edge where no lock is held and at least one request is high. Then a purely combinational priority function reads only that captured vector and picks one winner. Requests that change after the capture are not seen until the next capture. The grant stays with the winner until that client lowers its request. The lock then opens, and requests that were still pending are captured again together with any new ones.

A static mode input chooses the priority function. It is sampled only at the capture edge. In group mode, the group holding more captured requests wins, and a tie goes to the lower-numbered group. Inside the winning group, the lowest-numbered request wins. In linear mode, the lowest-numbered captured request wins. If a captured vector could produce no winner, the lock is cleared at once so that the arbiter can never stall.

Top module: `grp_snap_arbiter`

## Requirements
- R1: While reset is low and on the first sample after reset, `grant_o` is all zero.
- R2: At a rising edge where no lock is held and `req_i` is nonzero, the vector is captured. `grant_o` shows the winner immediately after that edge. With no requests, no grant is ever raised.
- R3: While a lock is held, changes on `req_i` other than the winner's own bit do not alter `grant_o`.
- R4: The grant stays up while the winner's request is high. At the first rising edge where the winner's request is low, the lock is released, and `grant_o` is zero for the following cycle. A capture can occur at the next edge after that. A captured vector that yields no winner releases the lock the same way.
- R5: Group mode is `mode_i` = 1. Bits 0 and 1 form group 0, and bits 2 and 3 form group 1. The group with more captured requests wins, and an equal count goes to group 0.
- R6: Within the winning group, the captured request with the lowest bit index is granted.
- R7: Linear mode is `mode_i` = 0. The captured request with the lowest bit index is granted.
- R8: `grant_o` is zero or one-hot, and its bit was set in `req_i` at the capture edge. A captured request that loses stays pending while the client holds it, and it competes again in later captures.
- R9: `mode_i` is sampled only at the capture edge. Changing it while a lock is held has no effect on `grant_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_REQ | Level request per client, held until served |
| mode_i | input | 1 | 1 selects group priority, 0 selects linear priority |
| grant_o | output | NUM_REQ | One-hot grant, zero when no lock is held |

## Verification
There is one register between the capture edge and `grant_o`, so a grant is due right after the edge that sees requests while the arbiter is unlocked. A release is due right after the edge that sees the winner's request low, and a new capture can come at the edge after that. The bench keeps a cycle model that it updates on each rising edge. It drives inputs and compares `grant_o` at falling edges, so every comparison lands half a cycle after the edge that should have produced the value. Directed steps check group majority, ties, in-group order, linear order, late arrivals and mid-lock mode changes at those same points, and a seeded random phase covers pending requests and re-capture.

// File: rtl/arb_snap_pkg.sv
package arb_snap_pkg;
  typedef enum logic {PRIO_LINEAR = 1'b0, PRIO_GROUP = 1'b1} prio_mode_e;

  // lowest set bit of a vector, returned as a one-hot mask
  function automatic logic [31:0] lowest_one(input logic [31:0] v);
    logic [31:0] r;
    r = '0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = 32'(1) << k;
    end
    return r;
  endfunction
endpackage

// File: rtl/snap_lock.sv
module snap_lock
  import arb_snap_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               mode_i,
  input  logic [NUM_REQ-1:0] grant_i,
  output logic               lock_q,
  output logic [NUM_REQ-1:0] snap_q,
  output prio_mode_e         mode_q,
  output logic               take_ev,
  output logic               release_ev
);
  logic nil_ev;

  assign take_ev    = !lock_q && (|req_i);
  assign nil_ev     = lock_q && (grant_i == '0);
  assign release_ev = lock_q && (nil_ev || ((req_i & grant_i) == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      snap_q <= '0;
      mode_q <= PRIO_LINEAR;
    end else if (take_ev) begin
      lock_q <= 1'b1;
      snap_q <= req_i;
      mode_q <= prio_mode_e'(mode_i);
    end else if (release_ev) begin
      lock_q <= 1'b0;
      snap_q <= '0;
    end
  end

  assert_snap_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !release_ev) |=> (lock_q && $stable(snap_q)));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> !lock_q);
  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (!lock_q || $stable(mode_q)));
  assert_take_sees_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> (lock_q && snap_q == $past(req_i)));
endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import arb_snap_pkg::*;
#(
  parameter int GRP_SIZE = 2,
  parameter int NUM_GRP  = 2,
  parameter int NUM_REQ  = GRP_SIZE * NUM_GRP
) (
  input  logic               valid_i,
  input  logic [NUM_REQ-1:0] snap_i,
  input  prio_mode_e         mode_i,
  output logic [NUM_REQ-1:0] grant_o
);
  localparam int CW = $clog2(GRP_SIZE + 1);
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic [CW-1:0]      grp_cnt [NUM_GRP];
  logic [GW-1:0]      best_grp;
  logic [NUM_REQ-1:0] grp_mask;
  logic [NUM_REQ-1:0] lin_pick;
  logic [NUM_REQ-1:0] grp_pick;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_cnt
    always_comb begin
      grp_cnt[g] = '0;
      for (int b = 0; b < GRP_SIZE; b++)
        grp_cnt[g] = grp_cnt[g] + CW'(snap_i[g*GRP_SIZE+b]);
    end
  end

  // strict compare keeps ties on the lower-numbered group
  always_comb begin
    best_grp = '0;
    for (int g = 1; g < NUM_GRP; g++)
      if (grp_cnt[g] > grp_cnt[best_grp]) best_grp = GW'(g);
  end

  always_comb begin
    grp_mask = '0;
    for (int b = 0; b < GRP_SIZE; b++)
      grp_mask[int'(best_grp)*GRP_SIZE+b] = 1'b1;
  end

  assign lin_pick = NUM_REQ'(lowest_one(32'(snap_i)));
  assign grp_pick = NUM_REQ'(lowest_one(32'(snap_i & grp_mask)));
  assign grant_o  = !valid_i ? '0 : (mode_i == PRIO_GROUP) ? grp_pick : lin_pick;

  always_comb begin
    assert_pick_onehot_R8: assert ($onehot0(grant_o));
    assert_pick_in_snap_R8: assert ((grant_o & ~snap_i) == '0);
  end
endmodule

// File: rtl/grp_snap_arbiter.sv
module grp_snap_arbiter
  import arb_snap_pkg::*;
#(
  parameter int GRP_SIZE = 2,
  parameter int NUM_GRP  = 2,
  parameter int NUM_REQ  = GRP_SIZE * NUM_GRP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               mode_i,
  output logic [NUM_REQ-1:0] grant_o
);
  logic               lock_q;
  logic [NUM_REQ-1:0] snap_q;
  prio_mode_e         mode_q;
  logic               take_ev;
  logic               release_ev;
  logic [NUM_REQ-1:0] pick;

  snap_lock #(.NUM_REQ(NUM_REQ)) u_lock (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
    .grant_i(pick), .lock_q(lock_q), .snap_q(snap_q), .mode_q(mode_q),
    .take_ev(take_ev), .release_ev(release_ev)
  );

  prio_pick #(.GRP_SIZE(GRP_SIZE), .NUM_GRP(NUM_GRP), .NUM_REQ(NUM_REQ)) u_pick (
    .valid_i(lock_q), .snap_i(snap_q), .mode_i(mode_q), .grant_o(pick)
  );

  assign grant_o = pick;

  assert_gap_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> (grant_o == '0));
  assert_grant_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant_o) |-> $past(|req_i));
  assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && ((grant_o & req_i) != '0)) |=> $stable(grant_o));
endmodule

// File: tb/grp_snap_arbiter_tb_top.sv
module grp_snap_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = 4'b0;
  logic       mode = 1'b1;
  logic [3:0] grant;
  int checks = 0;
  int errors = 0;
  bit run_chk = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  grp_snap_arbiter dut_i (.clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .grant_o(grant));

  function automatic logic [3:0] ref_pick(input logic [3:0] s, input logic grp);
    int n0, n1;
    logic [3:0] cand;
    n0 = s[0] + s[1];
    n1 = s[2] + s[3];
    if (!grp) cand = s;
    else if (n1 > n0) cand = s & 4'b1100;
    else cand = s & 4'b0011;
    if (cand[0]) return 4'b0001;
    if (cand[1]) return 4'b0010;
    if (cand[2]) return 4'b0100;
    if (cand[3]) return 4'b1000;
    return 4'b0000;
  endfunction

  logic       m_lock;
  logic [3:0] m_snap;
  logic       m_mode;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_lock = 0; m_snap = 0; m_mode = 0;
    end else if (!m_lock) begin
      if (req != 0) begin m_lock = 1; m_snap = req; m_mode = mode; end
    end else if ((req & ref_pick(m_snap, m_mode)) == 0) begin
      m_lock = 0; m_snap = 0;
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected=%b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk && rst_n) begin
      check(m_mode ? "R5/R6 model" : "R7 model", grant, m_lock ? ref_pick(m_snap, m_mode) : 4'b0);
      check("R8 onehot", 4'($countones(grant) <= 1), 4'b1);
    end
  end

  task automatic step(input logic [3:0] r, input logic md);
    @(negedge clk);
    req = r; mode = md;
  endtask

  initial begin
    @(negedge clk);
    check("R1 in reset", grant, 4'b0000);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", grant, 4'b0000);
    check("R2 idle no grant", grant, 4'b0000);
    req = 4'b1101; mode = 1'b1;
    @(negedge clk);
    check("R5 group majority", grant, 4'b0100);
    req = 4'b1111; mode = 1'b0;
    @(negedge clk);
    check("R3 late arrival ignored", grant, 4'b0100);
    check("R9 mode change ignored", grant, 4'b0100);
    req = 4'b1011;
    @(negedge clk);
    check("R4 release gap", grant, 4'b0000);
    @(negedge clk);
    check("R7 linear lowest", grant, 4'b0001);
    check("R8 pending recaptured", grant & 4'b1011, grant);
    req = 4'b1010; mode = 1'b1;
    @(negedge clk);
    check("R4 release gap 2", grant, 4'b0000);
    @(negedge clk);
    check("R5 tie to group 0", grant, 4'b0010);
    req = 4'b1100;
    @(negedge clk);
    @(negedge clk);
    check("R6 lowest in group", grant, 4'b0100);
    req = 4'b0000;
    @(negedge clk);
    @(negedge clk);
    check("R2 no request no grant", grant, 4'b0000);
    run_chk = 1;
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] nr;
      logic nm;
      @(negedge clk);
      #1;
      nr = req; nm = mode;
      for (int i = 0; i < 4; i++) begin
        if (!req[i]) begin
          if ($urandom_range(3) == 0) nr[i] = 1'b1;
        end else if (grant[i]) begin
          if ($urandom_range(1) == 0) nr[i] = 1'b0;
        end
      end
      if ($urandom_range(7) == 0) nm = ~mode;
      req = nr; mode = nm;
    end
    run_chk = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end (cycle %0d)", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule